// File: doc/BRIEF.md
# Serial-In Strobed Latch Register

The block turns a serial bit stream into eight parallel channel drive signals. A shift clock input (`sclk`) is sampled in the system clock domain. On each low-to-high transition of `sclk`, one bit enters stage 1 of an eight-stage shift path and every stored bit moves one stage further. The last stage is brought out on `sdo`, so several copies can be chained: the `sdo` of one block feeds the `sdi` of the next, and all copies share `sclk` and `strobe`.

A bank of output latches sits behind the shift path. While `strobe` is high, the latches take a copy of the shift stages on every system clock edge. While `strobe` is low, they hold their contents. Raising `clear` makes every shift step load a zero instead of `sdi`. A clear therefore reaches the channels only after shift steps and a strobe. The active-low enable `en_n` and the external `force_off` input both blank all eight drives without touching stored data. A drive value of 1 means the channel sinks current.

The shift clock is tracked by a two-state edge tracker. The states are `SCK_LOW` and `SCK_HIGH`. The transition `SCK_LOW -> SCK_HIGH` is the only one that issues a shift step. `SCK_HIGH -> SCK_LOW` issues nothing. Reset enters `SCK_HIGH`, so an `sclk` that is already high when reset is released does not count as an edge.

Top module: `sbl_serial_driver`

## Requirements
- R1: A shift step occurs once per low-to-high transition of `sclk`. Holding `sclk` high causes no further steps. On a step, stage 1 (drive bit 0) takes the serial input and stage k+1 takes the old stage k.
- R2: While `clear` is high, each shift step loads 0 into stage 1, whatever the value of `sdi`.
- R3: With `strobe` high, the latches copy the shift stages on every system clock edge. With `strobe` low, the latches hold their value even while the shift path changes.
- R4: A clear reaches `drive` only once the zeros have been shifted in and a strobe has followed.
- R5: With `en_n` high, `drive` is all zeros. Latch and shift contents are kept, and the old pattern returns when `en_n` goes low.
- R6: With `en_n` and `force_off` both low, `drive[i]` equals the latch bit of stage i+1. Shifting the bits of a byte in from bit 7 down to bit 0 and then strobing shows that byte on `drive`.
- R7: `sdo` is the content of stage 8. After a byte is loaded, each further step presents the next lower byte bit on `sdo`.
- R8: With `force_off` high, `drive` is all zeros, and stored state is kept exactly as it is for R5.
- R9: After reset, all stages and latches are zero, `drive` and `sdo` are 0, and an `sclk` that is high at reset release causes no shift step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Shift clock, sampled; rising transition shifts |
| sdi | input | 1 | Serial data into stage 1 |
| clear | input | 1 | Forces zeros into the shift path |
| strobe | input | 1 | Level-enabled latch update |
| en_n | input | 1 | Active-low output enable |
| force_off | input | 1 | External blanking of all drives |
| sdo | output | 1 | Stage 8 content, for cascading |
| drive | output | 8 | Channel drives, 1 = on |

## Verification
The hardest situations to reach from the ports are those where stored state must be shown to be unchanged while it is hidden. One example is a freshly shifted pattern, or a shifted-in clear, sitting behind latches that have not been strobed. The other is a latched pattern kept dark by `en_n` or `force_off`. The bench reaches these by loading a known byte and changing the shift path or the blanking inputs. It then checks that `drive` still shows the old byte, or turns fully off, and finally releases blanking or strobes to prove the stored bits were kept. The case of `sclk` held high across reset release and for many cycles afterwards is driven on purpose. A single extra shift step would show up as a 1 on `drive` after a strobe.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
    localparam int unsigned SBL_CHANNELS = 8;

    typedef enum logic {
        SCK_LOW  = 1'b0,
        SCK_HIGH = 1'b1
    } sck_state_e;
endpackage

// File: rtl/sbl_edge.sv
module sbl_edge
    import sbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic step
);
    sck_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCK_LOW:  if (sclk)  state_d = SCK_HIGH;
            SCK_HIGH: if (!sclk) state_d = SCK_LOW;
            default:  state_d = SCK_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCK_HIGH;
        else        state_q <= state_d;
    end

    // Only the LOW -> HIGH transition issues a step.
    always_comb begin
        step = 1'b0;
        unique case (state_q)
            SCK_LOW:  step = sclk;
            SCK_HIGH: step = 1'b0;
            default:  step = 1'b0;
        endcase
    end

    // R1: one step per edge, never two in a row
    a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
endmodule

// File: rtl/sbl_shift.sv
module sbl_shift #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    input  logic         sdi,
    output logic [N-1:0] stages
);
    logic [N-1:0] stages_q;
    logic         entry_bit;

    assign entry_bit = clr ? 1'b0 : sdi;

    always_ff @(posedge clk) begin
        if (!rst_n)    stages_q <= '0;
        else if (step) stages_q <= {stages_q[N-2:0], entry_bit};
    end

    assign stages = stages_q;

    a_r1_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (stages_q[N-1:1] == $past(stages_q[N-2:0])));
    a_r1_no_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(stages_q));
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && clr) |=> !stages_q[0]);
endmodule

// File: rtl/sbl_latch.sv
module sbl_latch #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] q_r;

    always_ff @(posedge clk) begin
        if (!rst_n)    q_r <= '0;
        else if (load) q_r <= d;
    end

    assign q = q_r;

    a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q_r == $past(d)));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q_r));
endmodule

// File: rtl/sbl_serial_driver.sv
module sbl_serial_driver
    import sbl_pkg::*;
#(
    parameter int unsigned N = SBL_CHANNELS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         sdi,
    input  logic         clear,
    input  logic         strobe,
    input  logic         en_n,
    input  logic         force_off,
    output logic         sdo,
    output logic [N-1:0] drive
);
    localparam int unsigned LAST = N - 1;

    logic         step;
    logic [N-1:0] stages;
    logic [N-1:0] held;
    logic         blank;

    sbl_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .step  (step)
    );

    sbl_shift #(.N(N)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .clr    (clear),
        .sdi    (sdi),
        .stages (stages)
    );

    sbl_latch #(.N(N)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strobe),
        .d     (stages),
        .q     (held)
    );

    assign blank = en_n | force_off;
    assign sdo   = stages[LAST];

    for (genvar g = 0; g < N; g++) begin : g_chan
        assign drive[g] = held[g] & ~blank;
    end

    // R5/R8: blanking never disturbs the latches
    a_r5_blank_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !strobe) |=> $stable(held));
endmodule

// File: tb/tb_sbl_serial_driver.sv
module tb_sbl_serial_driver;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int NVEC = 6;
    // {pattern, en_n, force_off}
    localparam logic [9:0] VEC [NVEC] = '{
        {8'hA5, 1'b0, 1'b0},
        {8'h3C, 1'b0, 1'b0},
        {8'hFF, 1'b1, 1'b0},
        {8'h81, 1'b0, 1'b1},
        {8'h01, 1'b0, 1'b0},
        {8'h80, 1'b0, 1'b0}
    };

    logic clk = 0, rst_n = 0, sclk = 0, sdi = 0, clear = 0, strobe = 0;
    logic en_n = 0, force_off = 0;
    logic sdo;
    logic [N-1:0] drive;
    int checks = 0, failures = 0;
    bit done = 0;

    sbl_serial_driver #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .clear(clear),
        .strobe(strobe), .en_n(en_n), .force_off(force_off),
        .sdo(sdo), .drive(drive)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic b, input logic c);
        @(negedge clk); sdi = b; clear = c; sclk = 1;
        @(negedge clk); sclk = 0;
        @(negedge clk); clear = 0;
    endtask

    task automatic load_byte(input logic [N-1:0] p);
        for (int k = N - 1; k >= 0; k--) push(p[k], 1'b0);
    endtask

    task automatic pulse_strobe();
        @(negedge clk); strobe = 1;
        @(negedge clk); strobe = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 drive after reset", drive, 8'h00);
        chk("R9 sdo after reset", {7'd0, sdo}, 8'h00);

        // table walk: R6 / R5 / R8 / R7
        prev = 8'h00;
        for (int i = 0; i < NVEC; i++) begin
            logic [N-1:0] p;
            p = VEC[i][9:2];
            en_n = 0; force_off = 0;
            load_byte(p);
            chk("R3 latch holds before strobe", drive, prev);
            chk("R7 sdo is stage 8", {7'd0, sdo}, {7'd0, p[7]});
            pulse_strobe();
            en_n = VEC[i][1]; force_off = VEC[i][0];
            @(negedge clk);
            chk("R5/R8/R6 gated drive", drive, (VEC[i][1] | VEC[i][0]) ? 8'h00 : p);
            en_n = 0; force_off = 0;
            @(negedge clk);
            chk("R6 drive equals latch", drive, p);
            prev = p;
        end

        // R7 cascade order on sdo
        load_byte(8'hB4);
        for (int k = 1; k < N; k++) begin
            logic [N-1:0] ref_b;
            ref_b = 8'hB4;
            push(1'b0, 1'b0);
            chk("R7 cascade bit", {7'd0, sdo}, {7'd0, ref_b[7-k]});
        end

        // R2/R4 clear path
        load_byte(8'h5A);
        pulse_strobe();
        for (int k = 0; k < N; k++) push(1'b1, 1'b1);
        chk("R4 clear not on drive before strobe", drive, 8'h5A);
        chk("R2 zeros reached stage 8", {7'd0, sdo}, 8'h00);
        pulse_strobe();
        chk("R2 R4 clear after strobe", drive, 8'h00);

        // R5 state kept while blanked, shift intact too
        load_byte(8'hC3);
        en_n = 1;
        pulse_strobe();
        chk("R5 blanked", drive, 8'h00);
        en_n = 0;
        @(negedge clk);
        chk("R5 pattern returns", drive, 8'hC3);
        force_off = 1;
        @(negedge clk);
        chk("R8 force_off blanks", drive, 8'h00);
        force_off = 0;
        @(negedge clk);
        chk("R8 pattern kept", drive, 8'hC3);

        // R1 sclk held high: one step only
        load_byte(8'h00);
        @(negedge clk); sdi = 1; sclk = 1;
        repeat (6) @(negedge clk);
        sclk = 0; sdi = 0;
        @(negedge clk);
        pulse_strobe();
        chk("R1 single step while sclk held", drive, 8'h01);

        // R9 sclk high across reset release
        @(negedge clk); rst_n = 0; sclk = 1; sdi = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        pulse_strobe();
        chk("R9 no spurious step", drive, 8'h00);
        sclk = 0;
        @(negedge clk);
        push(1'b1, 1'b0);
        pulse_strobe();
        chk("R1 step after reset", drive, 8'h01);

        finish_run();
    end
endmodule